// File: doc/BRIEF.md
# Raw Random Bit Conditioner

This block takes a raw random bit stream, sampled at most once per system clock, and turns it into a whitened stream at one quarter of the accepted raw rate. Every group of four accepted raw bits is folded into one bit by an XOR chain. That folded bit is then XORed with the current output bit of a 16-bit maximal-length linear feedback shift register (an m-sequence). The result appears on a registered output bit with a one-cycle valid pulse.

The stream is accepted only on cycles where both the enable and the raw valid strobe are high. Gaps in either input stall the grouping rather than breaking it. A synchronous clear returns the fold state and the sequence generator to their starting values without an asynchronous reset. The entropy source that feeds the raw input, and any health testing, sit outside this block.

Top module: `trng_postproc`

## Requirements
- R1: After the asynchronous reset `rst_ni` is released, `out_vld_o` is 0 and `out_o` is 0.
- R2: `out_vld_o` is high for exactly one cycle, in the cycle after the clock edge that accepts the fourth raw bit of a group. A raw bit is accepted when `en_i` and `raw_vld_i` are both 1 at that edge.
- R3: The output bit is the XOR of the four accepted raw bits of its group, XORed with bit 15 of the sequence register as it was before that group's output.
- R4: The sequence register resets to 16'hACE1. With state s, it advances to {s[14:0], s[15]^s[13]^s[12]^s[10]}, exactly once per output bit. For example, the first output of four raw ones is 1.
- R5: A raw bit presented with `raw_vld_i` = 0 is ignored. It does not count toward the group and does not enter the XOR.
- R6: While `en_i` = 0, the group count, the fold accumulator and the sequence register hold their values, no valid pulse is produced, and raw input is ignored.
- R7: `clr_i` = 1 at a clock edge clears the group count and the accumulator, reloads 16'hACE1, and forces `out_vld_o` and `out_o` to 0 in the following cycle. It takes priority over `en_i`.
- R8: `out_o` keeps its value in every cycle in which no new output is produced and no clear occurs.
- R9: When raw bits are accepted on every cycle, `out_vld_o` pulses on every fourth cycle and never in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clr_i | input | 1 | Synchronous clear of all conditioning state |
| en_i | input | 1 | Enable; low freezes all state |
| raw_i | input | 1 | Raw random bit |
| raw_vld_i | input | 1 | Raw bit qualifier |
| out_o | output | 1 | Conditioned output bit |
| out_vld_o | output | 1 | One-cycle pulse marking a new output bit |

## Verification
The bench targets the cases where grouping can slip:
- Gaps in `raw_vld_i` and in `en_i` fall in the middle of a group. A design that counted unqualified bits would emit early, with a wrong parity.
- A clear arrives mid-group. A design that kept a stale accumulator or a stale sequence state would produce outputs that differ from the model from then on.
- A long run of all-zero raw input exposes the bare m-sequence. Wrong taps or an extra advance per output show up within a few outputs.
- `out_o` is compared on every cycle, not only on valid cycles. A design that let the output drift between pulses is caught that way.

// File: rtl/trng_pp_pkg.sv
package trng_pp_pkg;
  localparam int unsigned SEQ_W     = 16;
  localparam logic [SEQ_W-1:0] SEQ_SEED = 16'hACE1;
  // feedback taps at stages 16,14,13,11
  localparam logic [SEQ_W-1:0] SEQ_TAPS = 16'hB400;
  localparam int unsigned GROUP_N   = 4;

  function automatic logic [SEQ_W-1:0] seq_next(input logic [SEQ_W-1:0] s);
    return {s[SEQ_W-2:0], ^(s & SEQ_TAPS)};
  endfunction
endpackage

// File: rtl/trng_xor_fold.sv
module trng_xor_fold #(
  parameter int unsigned GROUP = 4,
  localparam int unsigned PH_W = (GROUP > 1) ? $clog2(GROUP) : 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic take_i,
  input  logic bit_i,
  output logic fold_o,
  output logic done_o
);
  logic [PH_W-1:0] phase_q;
  logic            acc_q;
  logic            last;

  assign last   = (phase_q == PH_W'(GROUP - 1));
  assign fold_o = acc_q ^ bit_i;
  assign done_o = take_i && last && !clr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= '0;
      acc_q   <= 1'b0;
    end else if (clr_i) begin
      phase_q <= '0;
      acc_q   <= 1'b0;
    end else if (take_i) begin
      if (last) begin
        phase_q <= '0;
        acc_q   <= 1'b0;
      end else begin
        phase_q <= phase_q + 1'b1;
        acc_q   <= acc_q ^ bit_i;
      end
    end
  end

  // R2
  phase_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_i && last && !clr_i) |=> (phase_q == '0 && !acc_q));

  // R5
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!take_i && !clr_i) |=> ($stable(phase_q) && $stable(acc_q)));

  // R7
  clr_fold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (phase_q == '0 && !acc_q));
endmodule

// File: rtl/trng_mseq.sv
module trng_mseq
  import trng_pp_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic step_i,
  output logic bit_o
);
  logic [SEQ_W-1:0] state_q;

  assign bit_o = state_q[SEQ_W-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      state_q <= SEQ_SEED;
    else if (clr_i)   state_q <= SEQ_SEED;
    else if (step_i)  state_q <= seq_next(state_q);
  end

  // R4
  seq_nonzero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q != '0);

  // R6
  seq_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!step_i && !clr_i) |=> $stable(state_q));

  // R4
  seq_shift_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !clr_i) |=> (state_q[SEQ_W-1:1] == $past(state_q[SEQ_W-2:0])));
endmodule

// File: rtl/trng_postproc.sv
module trng_postproc
  import trng_pp_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic en_i,
  input  logic raw_i,
  input  logic raw_vld_i,
  output logic out_o,
  output logic out_vld_o
);
  logic take;
  logic fold_bit;
  logic fire;
  logic mask_bit;

  assign take = en_i && raw_vld_i;

  trng_xor_fold #(.GROUP(GROUP_N)) i_fold (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr_i),
    .take_i (take),
    .bit_i  (raw_i),
    .fold_o (fold_bit),
    .done_o (fire)
  );

  trng_mseq i_mseq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr_i),
    .step_i (fire),
    .bit_o  (mask_bit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_o     <= 1'b0;
      out_vld_o <= 1'b0;
    end else if (clr_i) begin
      out_o     <= 1'b0;
      out_vld_o <= 1'b0;
    end else begin
      out_vld_o <= fire;
      if (fire) out_o <= fold_bit ^ mask_bit;
    end
  end

  // R9
  vld_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_vld_o |=> !out_vld_o);

  // R8
  out_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fire && !clr_i) |=> $stable(out_o));

  // R6
  en_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i || clr_i) |=> !out_vld_o);

  // R7
  clr_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (!out_vld_o && !out_o));
endmodule

// File: tb/test_trng_postproc.sv
`timescale 1ns/1ps
module test_trng_postproc;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic clr_i = 1'b0, en_i = 1'b0, raw_i = 1'b0, raw_vld_i = 1'b0;
  logic out_o, out_vld_o;

  int checks = 0;
  int errors = 0;

  logic [15:0] m_seq;
  logic        m_acc;
  int          m_ph;
  logic        m_out, m_vld;
  int          vld_count;

  always #2.5 clk_i = ~clk_i;

  trng_postproc i_trng_postproc (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr_i), .en_i(en_i),
    .raw_i(raw_i), .raw_vld_i(raw_vld_i), .out_o(out_o), .out_vld_o(out_vld_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_seq = 16'hACE1; m_acc = 1'b0; m_ph = 0; m_out = 1'b0; m_vld = 1'b0;
  endtask

  // one clock: drive at negedge, update model, check 1 ns after posedge
  task automatic cyc(input logic c, input logic e, input logic r, input logic v,
                     input string tag);
    @(negedge clk_i);
    clr_i = c; en_i = e; raw_i = r; raw_vld_i = v;
    if (c) begin
      model_reset();
    end else if (e && v) begin
      if (m_ph == 3) begin
        m_out = m_acc ^ r ^ m_seq[15];
        m_vld = 1'b1;
        m_seq = {m_seq[14:0], m_seq[15]^m_seq[13]^m_seq[12]^m_seq[10]};
        m_ph = 0; m_acc = 1'b0;
      end else begin
        m_acc = m_acc ^ r; m_ph++; m_vld = 1'b0;
      end
    end else begin
      m_vld = 1'b0;
    end
    @(posedge clk_i);
    #1;
    if (out_vld_o) vld_count++;
    chk(out_vld_o == m_vld, {tag, " vld"}, out_vld_o, m_vld);
    chk(out_o == m_out, {tag, " out"}, out_o, m_out);
  endtask

  task automatic t_reset();
    rst_ni = 1'b0; model_reset();
    repeat (3) @(posedge clk_i);
    #1;
    chk(out_vld_o == 1'b0, "R1 vld", out_vld_o, 0);
    chk(out_o == 1'b0, "R1 out", out_o, 0);
    @(negedge clk_i); rst_ni = 1'b1;
  endtask

  task automatic t_first_value();
    for (int i = 0; i < 4; i++) cyc(0, 1, 1, 1, "R3");
    chk(out_vld_o == 1'b1 && out_o == 1'b1, "R4 first", out_o, 1);
  endtask

  task automatic t_stream();
    vld_count = 0;
    for (int i = 0; i < 64; i++) cyc(0, 1, logic'((i * 5 + 3) % 7 < 3), 1, "R9");
    chk(vld_count == 16, "R9 rate", vld_count, 16);
  endtask

  task automatic t_gaps();
    vld_count = 0;
    for (int i = 0; i < 60; i++) cyc(0, 1, logic'(i % 3 == 0), logic'(i % 5 != 2), "R5");
    chk(vld_count == 12, "R5 count", vld_count, 12);
  endtask

  task automatic t_enable();
    for (int i = 0; i < 2; i++) cyc(0, 1, 1, 1, "R6");
    vld_count = 0;
    for (int i = 0; i < 20; i++) cyc(0, 0, logic'(i[0]), 1, "R6");
    chk(vld_count == 0, "R6 count", vld_count, 0);
    for (int i = 0; i < 10; i++) cyc(0, 1, logic'(i[1]), 1, "R8");
  endtask

  task automatic t_clear();
    for (int i = 0; i < 6; i++) cyc(0, 1, 1, 1, "R7");
    cyc(1, 1, 1, 1, "R7");
    cyc(1, 0, 0, 0, "R7");
    for (int i = 0; i < 4; i++) cyc(0, 1, 1, 1, "R7");
    chk(out_o == 1'b1, "R7 reseed", out_o, 1);
  endtask

  task automatic t_mseq();
    vld_count = 0;
    for (int i = 0; i < 800; i++) cyc(0, 1, 0, 1, "R4");
    chk(vld_count == 200, "R4 count", vld_count, 200);
  endtask

  initial begin
    t_reset();
    t_first_value();
    t_stream();
    t_gaps();
    t_enable();
    t_clear();
    t_mseq();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    checks++; errors++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule